// File: doc/BRIEF.md
# Banked Direct-Address RAM Window

This block sits between the data-bus side of an 8-bit CPU and a 1 KB data RAM. The RAM holds 256 internal bytes and 768 expanded bytes. Direct accesses to the 64-byte window at 0x40–0x7F can be steered by a bank register onto any 64-byte slice of the whole 1 KB. The same register can also leave the window alone, so that it reaches ordinary lower RAM. Indirect accesses reach the 256 internal bytes unchanged. Paged accesses use an 8-bit pointer and a 2-bit page register to reach the expanded bytes. Full 16-bit external accesses reach the expanded bytes by absolute address.

The control registers sit in the direct space at 0x80 and above. An expanded-RAM enable gates every path that lands in the expanded 768 bytes. Each cycle the CPU presents at most one request. Read data comes back on the next cycle.

Top module: `bwin_top`

## Requirements
- R1: After reset the bank register reads 0x01 (window off, select 1), the page register reads 0x00, the expanded enable reads 0x00, and `rsp_rdata` is 0.
- R2: Take a direct access (`req_kind`=0) to 0x40–0x7F with the window on and select code c. It reaches physical byte c*64 + (address − 0x40). Codes 0–3 fall on internal bytes 0x000–0x0FF. Codes 4–15 fall on expanded offsets 0x0000–0x02FF, with code 4 at 0x0000 and code 15 at 0x02C0.
- R3: Write 0x88 to the bank register, then write a byte to direct address 0x41. The byte lands at expanded offset 0x0101 and an external read of 0x0101 returns it.
- R4: With the window off (bank register bit 7 = 0), direct 0x40–0x7F reach internal bytes 0x40–0x7F, whatever the select code holds.
- R5: Direct addresses 0x00–0x3F always reach internal bytes 0x00–0x3F.
- R6: Indirect accesses (`req_kind`=1) use `req_addr[7:0]` as an internal byte address 0x00–0xFF, with no remapping.
- R7: Paged accesses (`req_kind`=2) with page code p of 0, 1 or 2 (page register bits 1:0) reach expanded offset p*256 + `req_addr[7:0]`.
- R8: A paged access with page code 3 reads 0xFF and its write changes no RAM byte.
- R9: External accesses (`req_kind`=3) below 0x0300 reach that expanded offset. At 0x0300 and above they read 0xFF and their writes are ignored.
- R10: While the expanded enable is 0, any access that would land in the expanded bytes reads 0xFF and its write is ignored. This covers window, paged and external accesses alike.
- R11: The register layout is as follows. Direct 0xA8 is the bank register: bit 7 is the window enable and bits 3:0 are the select. Direct 0xA9 is the page register, bits 1:0. Direct 0xAA is the expanded enable, bit 0. Unused bits read 0. Other direct addresses from 0x80 up read 0 and ignore writes.
- R12: Data for a read appears on `rsp_rdata` in the cycle after the request. After a cycle with no read, `rsp_rdata` is 0. A register write governs the access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 paged, 3 external |
| req_addr | input | 16 | Address; only bits 7:0 used except for external |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, one cycle after the request |

## Verification
The bench builds the block with its defaults: 64-byte banks, a 4-bit select, a 2-bit page field, 256 internal plus 768 expanded bytes, and control registers at 0xA8–0xAA. At these sizes the bench can write the whole 1 KB in about a thousand cycles, so every later read has a known value. The bench can also sweep all sixteen bank codes, including both internal/expanded boundaries (codes 3/4) and the top bank. The 16-bit external path reaches the hole just above 0x02FF as well as the highest address.

// File: rtl/bwin_pkg.sv
// Package: shared encodings for the banked RAM window.
// Assumes one request per cycle and one read source per response.
package bwin_pkg;
    // Request path selected by the CPU side.
    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_PAGED    = 2'd2,
        ACC_EXTERNAL = 2'd3
    } acc_kind_e;

    // Origin of the byte returned in the next cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_REG  = 2'd2,
        SRC_HOLE = 2'd3
    } rd_src_e;
endpackage

// File: rtl/bwin_ctrl_regs.sv
// Module: control registers of the RAM window (bank, page, expanded enable).
// Does: holds the window enable and select, the page code and the expanded
// RAM enable; decodes register reads combinationally.
// Assumes: DATA_W >= SEL_W + 1 and DATA_W >= PAGE_W; unused bits read 0.
module bwin_ctrl_regs #(
    parameter int DATA_W = 8,
    parameter int SEL_W = 4,
    parameter int PAGE_W = 2,
    parameter logic [7:0] BANK_ADDR = 8'hA8,
    parameter logic [7:0] PAGE_ADDR = 8'hA9,
    parameter logic [7:0] XCTL_ADDR = 8'hAA,
    parameter logic [SEL_W-1:0] SEL_RESET = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              bank_en,
    output logic [SEL_W-1:0]  bank_sel,
    output logic [PAGE_W-1:0] page_sel,
    output logic              xram_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int GAP_LO = SEL_W;
    localparam int GAP_HI = DATA_W - 2;

    logic unused_gap;
    assign unused_gap = ^wdata[GAP_HI:GAP_LO];

    // Register update on writes, reset to identity mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en  <= 1'b0;
            bank_sel <= SEL_RESET;
            page_sel <= '0;
            xram_en  <= 1'b0;
        end else if (wr_en) begin
            if (reg_addr == BANK_ADDR) begin
                bank_en  <= wdata[DATA_W-1];
                bank_sel <= wdata[SEL_W-1:0];
            end
            if (reg_addr == PAGE_ADDR) page_sel <= wdata[PAGE_W-1:0];
            if (reg_addr == XCTL_ADDR) xram_en <= wdata[0];
        end
    end

    // Read decode; unknown addresses and unused bits give 0.
    always_comb begin
        rdata = '0;
        if (reg_addr == BANK_ADDR) begin
            rdata[DATA_W-1]  = bank_en;
            rdata[SEL_W-1:0] = bank_sel;
        end else if (reg_addr == PAGE_ADDR) begin
            rdata[PAGE_W-1:0] = page_sel;
        end else if (reg_addr == XCTL_ADDR) begin
            rdata[0] = xram_en;
        end
    end

    // R11: without a register write no control state moves.
    a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({bank_en, bank_sel, page_sel, xram_en}));
endmodule

// File: rtl/bwin_xlate.sv
// Module: address translator for the RAM window.
// Does: turns a request kind and address into a physical RAM byte, a
// register hit, or a hole (reads 0xFF, writes dropped).
// Assumes: physical byte = select * BANK_BYTES + offset covers the whole
// RAM, so INT_BYTES + EXP_BYTES == 2**SEL_W * BANK_BYTES; WIN_BASE is
// aligned to BANK_BYTES; pages are 256 bytes.
module bwin_xlate
    import bwin_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W = 4,
    parameter int PAGE_W = 2,
    parameter int BANK_BYTES = 64,
    parameter int INT_BYTES = 256,
    parameter int EXP_BYTES = 768,
    parameter int LOW_BYTES = 128,
    parameter logic [7:0] WIN_BASE = 8'h40,
    parameter int PHYS_W = $clog2(INT_BYTES + EXP_BYTES)
) (
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank_en,
    input  logic [SEL_W-1:0]  bank_sel,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              xram_en,
    output logic              to_ram,
    output logic              to_reg,
    output logic [PHYS_W-1:0] phys
);
    localparam int OFS_W = $clog2(BANK_BYTES);
    localparam int NUM_PAGES = EXP_BYTES / 256;
    localparam logic [8:0] WIN_END = 9'(WIN_BASE) + 9'(BANK_BYTES);

    logic [7:0] a8;
    logic       win_hit;
    logic       raw_ram;
    logic [PHYS_W-1:0] raw_phys;

    assign a8 = addr[7:0];
    assign win_hit = (a8 >= WIN_BASE) && (9'(a8) < WIN_END);

    // Per-kind address resolution before the expanded gate.
    always_comb begin
        raw_ram  = 1'b0;
        to_reg   = 1'b0;
        raw_phys = '0;
        case (kind)
            ACC_DIRECT: begin
                if (9'(a8) >= 9'(LOW_BYTES)) begin
                    to_reg = 1'b1;
                end else if (win_hit && bank_en) begin
                    raw_ram  = 1'b1;
                    raw_phys = PHYS_W'({bank_sel, a8[OFS_W-1:0]});
                end else begin
                    raw_ram  = 1'b1;
                    raw_phys = PHYS_W'(a8);
                end
            end
            ACC_INDIRECT: begin
                raw_ram  = 1'b1;
                raw_phys = PHYS_W'(a8);
            end
            ACC_PAGED: begin
                if (32'(page_sel) < NUM_PAGES) begin
                    raw_ram  = 1'b1;
                    raw_phys = PHYS_W'(INT_BYTES) + PHYS_W'({page_sel, a8});
                end
            end
            default: begin
                if (32'(addr) < EXP_BYTES) begin
                    raw_ram  = 1'b1;
                    raw_phys = PHYS_W'(INT_BYTES) + addr[PHYS_W-1:0];
                end
            end
        endcase
    end

    // Expanded gate: bytes above the internal range need the enable.
    always_comb begin
        phys   = raw_phys;
        to_ram = raw_ram && (xram_en || (32'(raw_phys) < INT_BYTES));
    end
endmodule

// File: rtl/bwin_ram.sv
// Module: behavioural single-port byte RAM for the window.
// Does: one write or one read per cycle; read data is registered.
// Assumes: we and re are never high together; contents are not reset.
module bwin_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH = 1024,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write and registered read.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/bwin_top.sv
// Module: banked direct-address RAM window, top level.
// Does: accepts one CPU data request per cycle, translates it, and returns
// read data one cycle later from RAM, control registers or a hole (0xFF).
// Assumes: the CPU holds no request open across cycles; reads in flight are
// not cancelled by reset release.
module bwin_top
    import bwin_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int SEL_W = 4,
    parameter int PAGE_W = 2,
    parameter int BANK_BYTES = 64,
    parameter int INT_BYTES = 256,
    parameter int EXP_BYTES = 768,
    parameter logic [7:0] WIN_BASE = 8'h40,
    parameter logic [7:0] BANK_ADDR = 8'hA8,
    parameter logic [7:0] PAGE_ADDR = 8'hA9,
    parameter logic [7:0] XCTL_ADDR = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int DEPTH = INT_BYTES + EXP_BYTES;
    localparam int PHYS_W = $clog2(DEPTH);

    acc_kind_e         kind;
    logic              rd_req, wr_req;
    logic              bank_en, xram_en;
    logic [SEL_W-1:0]  bank_sel;
    logic [PAGE_W-1:0] page_sel;
    logic              to_ram, to_reg;
    logic [PHYS_W-1:0] phys;
    logic [DATA_W-1:0] reg_rdata, reg_q, ram_rdata;
    logic              ram_we, ram_re;
    rd_src_e           src_q;

    assign kind   = acc_kind_e'(req_kind);
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;
    assign ram_we = wr_req && to_ram;
    assign ram_re = rd_req && to_ram;

    bwin_ctrl_regs #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W),
        .BANK_ADDR(BANK_ADDR), .PAGE_ADDR(PAGE_ADDR), .XCTL_ADDR(XCTL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_req && to_reg), .reg_addr(req_addr[7:0]), .wdata(req_wdata),
        .bank_en(bank_en), .bank_sel(bank_sel), .page_sel(page_sel),
        .xram_en(xram_en), .rdata(reg_rdata)
    );

    bwin_xlate #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W),
        .BANK_BYTES(BANK_BYTES), .INT_BYTES(INT_BYTES), .EXP_BYTES(EXP_BYTES),
        .WIN_BASE(WIN_BASE), .PHYS_W(PHYS_W)
    ) u_xlate (
        .kind(kind), .addr(req_addr), .bank_en(bank_en), .bank_sel(bank_sel),
        .page_sel(page_sel), .xram_en(xram_en),
        .to_ram(to_ram), .to_reg(to_reg), .phys(phys)
    );

    bwin_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .re(ram_re), .addr(phys),
        .wdata(req_wdata), .rdata(ram_rdata)
    );

    // Response source tag and captured register byte for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
            reg_q <= '0;
        end else begin
            if (!rd_req)     src_q <= SRC_NONE;
            else if (to_ram) src_q <= SRC_RAM;
            else if (to_reg) src_q <= SRC_REG;
            else             src_q <= SRC_HOLE;
            if (rd_req && to_reg) reg_q <= reg_rdata;
        end
    end

    // Response mux from the registered source.
    always_comb begin
        case (src_q)
            SRC_RAM:  rsp_rdata = ram_rdata;
            SRC_REG:  rsp_rdata = reg_q;
            SRC_HOLE: rsp_rdata = '1;
            default:  rsp_rdata = '0;
        endcase
    end

    // R4: window off means direct window bytes stay in lower RAM.
    a_r4_no_remap_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_DIRECT && req_addr[7:6] == 2'b01 && !bank_en)
        |-> (to_ram && phys == PHYS_W'(req_addr[7:0])));

    // R5: direct bytes below the window are never moved.
    a_r5_low_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_DIRECT && req_addr[7:6] == 2'b00)
        |-> (to_ram && phys == PHYS_W'(req_addr[7:0])));

    // R8: page code 3 touches no RAM byte.
    a_r8_page_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_PAGED && page_sel == '1) |-> !(ram_we || ram_re));

    // R9: external reads past the expanded range return all ones.
    a_r9_ext_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && kind == ACC_EXTERNAL && 32'(req_addr) >= EXP_BYTES)
        |=> (rsp_rdata == '1));

    // R10: no write reaches expanded bytes while they are disabled.
    a_r10_gate_expanded: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && 32'(phys) >= INT_BYTES) |-> xram_en);

    // R12: a cycle without a read yields zero on the response.
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_bwin_top.sv
`timescale 1ns/1ps
module tb_bwin_top;
    localparam int K_DIR = 0, K_IND = 1, K_PAG = 2, K_EXT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;

    int checks = 0, fails = 0;

    // Reference state.
    bit       m_en = 0;
    int       m_sel = 1, m_page = 0;
    bit       m_xen = 0;
    int       m_mem [1024];

    bwin_top dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
                  .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
                  .rsp_rdata(rsp_rdata));

    always #4 clk = ~clk;

    // Physical byte for a request, -1 for a hole, -2 for register space.
    function automatic int resolve(int k, int a);
        int a8 = a & 255;
        int p;
        case (k)
            K_DIR: begin
                if (a8 >= 128) return -2;
                if (a8 >= 64 && m_en) p = m_sel * 64 + (a8 - 64);
                else p = a8;
            end
            K_IND: p = a8;
            K_PAG: begin
                if (m_page == 3) return -1;
                p = 256 + m_page * 256 + a8;
            end
            default: begin
                if (a >= 768) return -1;
                p = 256 + a;
            end
        endcase
        if (p >= 256 && !m_xen) return -1;
        return p;
    endfunction

    function automatic int reg_read(int a8);
        if (a8 == 'hA8) return (m_en ? 128 : 0) + m_sel;
        if (a8 == 'hA9) return m_page;
        if (a8 == 'hAA) return m_xen ? 1 : 0;
        return 0;
    endfunction

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    // One request: drive at negedge, update model, check response one cycle on.
    task automatic op(input int k, input bit w, input int a, input int d, input string tag);
        int p = resolve(k, a);
        int exp = 0;
        if (!w) begin
            if (p == -1) exp = 255;
            else if (p == -2) exp = reg_read(a & 255);
            else exp = m_mem[p];
        end else begin
            if (p >= 0) m_mem[p] = d & 255;
            else if (p == -2) begin
                if ((a & 255) == 'hA8) begin m_en = d[7]; m_sel = d & 15; end
                if ((a & 255) == 'hA9) m_page = d & 3;
                if ((a & 255) == 'hAA) m_xen = d[0];
            end
        end
        req_valid = 1'b1; req_write = w; req_kind = 2'(k);
        req_addr = 16'(a); req_wdata = 8'(d);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(int'(rsp_rdata), exp, tag);
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(int'(rsp_rdata), 0, tag);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(int'(rsp_rdata), 0, "R1 rsp in reset");
        rst_n = 1'b1;
        op(K_DIR, 0, 'hA8, 0, "R1 bank reg");
        op(K_DIR, 0, 'hA9, 0, "R1 page reg");
        op(K_DIR, 0, 'hAA, 0, "R1 xen reg");
        // R10: expanded gated at reset.
        op(K_EXT, 1, 'h0010, 'h5A, "R10 ext write gated");
        op(K_EXT, 0, 'h0010, 0, "R10 ext read gated");
        op(K_PAG, 0, 'h0033, 0, "R10 paged read gated");
        // Fill the whole RAM.
        op(K_DIR, 1, 'hAA, 1, "R11 xen on");
        for (int i = 0; i < 768; i++) op(K_EXT, 1, i, (i * 7 + 3) & 255, "R9 fill");
        for (int i = 0; i < 256; i++) op(K_IND, 1, i, (i * 13 + 1) & 255, "R6 fill");
        // R10: disable again, window and external writes dropped.
        op(K_DIR, 1, 'hAA, 0, "R10 xen off");
        op(K_EXT, 1, 'h0010, 'hEE, "R10 ext write dropped");
        op(K_DIR, 1, 'hA8, 'h86, "R10 bank 6");
        op(K_DIR, 0, 'h50, 0, "R10 window read gated");
        op(K_DIR, 1, 'h50, 'h77, "R10 window write dropped");
        op(K_DIR, 1, 'hAA, 1, "R10 xen on");
        op(K_EXT, 0, 'h0010, 0, "R10 ext kept");
        op(K_EXT, 0, 'h0090, 0, "R10 window byte kept");
        // R3 and R12: register write governs the next access.
        op(K_DIR, 1, 'hA8, 'h88, "R3 bank 8");
        op(K_DIR, 1, 'h41, 'h30, "R3 window write");
        op(K_EXT, 0, 'h0101, 0, "R3 read 0x0101");
        idle("R12 idle zero");
        // R2: every bank code, first and last byte.
        for (int c = 0; c < 16; c++) begin
            op(K_DIR, 1, 'hA8, 'h80 | c, "R2 select");
            op(K_DIR, 0, 'h40, 0, "R2 window low");
            op(K_DIR, 0, 'h7F, 0, "R2 window high");
            op(K_DIR, 1, 'h55, (c * 17 + 5) & 255, "R2 window write");
            if (c < 4) op(K_IND, 0, c * 64 + 'h15, 0, "R2 internal view");
            else op(K_EXT, 0, (c - 4) * 64 + 'h15, 0, "R2 expanded view");
        end
        // R4: window off.
        op(K_DIR, 1, 'hA8, 'h0F, "R4 off sel 15");
        op(K_DIR, 1, 'h45, 'hC4, "R4 write");
        op(K_IND, 0, 'h45, 0, "R4 internal view");
        op(K_EXT, 0, 'h02C5, 0, "R4 bank 15 untouched");
        // R5: low bytes fixed.
        op(K_DIR, 1, 'hA8, 'h89, "R5 sel 9");
        for (int i = 0; i < 64; i += 9) op(K_DIR, 0, i, 0, "R5 low read");
        op(K_DIR, 1, 'h3F, 'h99, "R5 low write");
        op(K_IND, 0, 'h3F, 0, "R5 internal view");
        // R6: upper internal via indirect.
        for (int i = 128; i < 256; i += 21) op(K_IND, 0, i, 0, "R6 upper read");
        // R7: paged.
        for (int pg = 0; pg < 3; pg++) begin
            op(K_DIR, 1, 'hA9, pg, "R7 page");
            op(K_PAG, 0, 'h00, 0, "R7 paged low");
            op(K_PAG, 0, 'hFF, 0, "R7 paged high");
            op(K_PAG, 1, 'h21, 'hA0 + pg, "R7 paged write");
            op(K_EXT, 0, pg * 256 + 'h21, 0, "R7 expanded view");
        end
        // R8: page code 3.
        op(K_DIR, 1, 'hA9, 3, "R8 page 3");
        op(K_PAG, 1, 'h21, 'h11, "R8 write dropped");
        op(K_PAG, 0, 'h21, 0, "R8 read hole");
        for (int pg = 0; pg < 3; pg++) op(K_EXT, 0, pg * 256 + 'h21, 0, "R8 pages kept");
        // R9: external range edge.
        op(K_EXT, 0, 'h02FF, 0, "R9 last byte");
        op(K_EXT, 1, 'h0300, 'h12, "R9 hole write");
        op(K_EXT, 0, 'h0300, 0, "R9 hole read");
        op(K_EXT, 0, 'hFFFF, 0, "R9 top read");
        // R11: unused bits and unknown addresses.
        op(K_DIR, 1, 'hA8, 'hFF, "R11 bank all ones");
        op(K_DIR, 0, 'hA8, 0, "R11 bank readback");
        op(K_DIR, 1, 'hA9, 'hFE, "R11 page all ones");
        op(K_DIR, 0, 'hA9, 0, "R11 page readback");
        op(K_DIR, 1, 'hAA, 'hFF, "R11 xen all ones");
        op(K_DIR, 0, 'hAA, 0, "R11 xen readback");
        op(K_DIR, 1, 'hB0, 'h5A, "R11 unknown write");
        op(K_DIR, 0, 'hB0, 0, "R11 unknown read");
        op(K_DIR, 0, 'hA8, 0, "R11 bank unchanged");
        idle("R12 idle after read");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule